// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Register Front End

This block sits between a simple register bus and four 12-bit digital-to-analog converter channels. The host places codes in per-channel holding registers and range settings in a pending range word. Neither reaches the converter pins when it is written. Each one is committed by a read access to a specific register. A read of the mode register commits the data codes, and a read of the range register commits the range settings. The converters themselves are outside the block. It drives four parallel 12-bit codes, one bipolar flag per channel and one gain flag per channel, and all of these are registered.

A shared mode register carries a global enable and a buffered-mode select. With buffered mode off, a data write passes straight to its channel's output on the next clock. With buffered mode on, the four outputs change only together, on an update read. The write and read ports are independent, so an update read and a write can arrive in the same cycle. In that case the update always uses the value held before the write.

Top module: `dbuf_dac_if`

## Requirements
- R1: After a synchronous reset, all four codes, all bipolar flags and all gain flags are zero.
- R2: Channel n's data register is at byte offset 0x14 + 2·n. Only bits 11:0 of a written word are kept, and bits 15:12 are ignored.
- R3: Bit 1 of the mode register at offset 0x02 is the enable. While it is 0, every code output is 0, but the holding registers still take writes. Setting it shows the held codes on the next clock.
- R4: With bit 0 of the mode register at 0 (direct mode), a data write to channel n changes only that channel's code, visible in the cycle after the write edge.
- R5: With bit 0 of the mode register at 1 (buffered mode), data writes leave every code output unchanged.
- R6: In buffered mode, a read of offset 0x02 copies all four holding registers to the code outputs at the same edge.
- R7: When an update read of 0x02 and a data write happen in the same cycle, the outputs take the value held before that write, and the new value stays in holding for the next update.
- R8: In the range register at offset 0x12, channel n's bipolar flag is bit 7−n and its gain flag is bit 11−n. A write changes no flag. A read of 0x12 commits the pending word, and a read in the same cycle as a write commits the older word.
- R9: Writing 0 to the mode register and 0 to the range register, then reading 0x12, brings every output back to its reset value.
- R10: The buffered select that applies to a data write is the one held before that cycle. A mode write made in the same cycle applies from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe (used as update event) |
| rd_addr | input | 8 | Read byte offset |
| dac_code_o | output | 48 | Channel n code in bits 12n+11:12n |
| dac_bipolar_o | output | 4 | Bipolar flag, bit n for channel n |
| dac_gain_o | output | 4 | Gain flag, bit n for channel n |

## Verification
The hardest situations to reach are collisions on the same edge: an update read landing with a data write, a range read landing with a range write, and a mode change landing with a data write. Directed steps drive the write port and the read port together to build each collision, and the expected outputs are worked out by hand. After that, a long stretch of mixed traffic sends random reads and writes to both ports at once. A behavioural model tracks that traffic and is compared with the outputs on every clock.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int unsigned DEF_NCH = 4;
  localparam int unsigned DEF_CW  = 12;
  localparam int unsigned DEF_DW  = 16;
  localparam int unsigned DEF_AW  = 8;

  localparam int unsigned OFS_MODE  = 32'h02;
  localparam int unsigned OFS_RANGE = 32'h12;
  localparam int unsigned OFS_DATA0 = 32'h14;
  localparam int unsigned OFS_STEP  = 2;

  localparam int unsigned EN_BIT   = 1;
  localparam int unsigned BUF_BIT  = 0;
  localparam int unsigned BIP_TOP  = 7;
  localparam int unsigned GAIN_TOP = 11;

  typedef struct packed {
    logic en;
    logic buffered;
  } mode_t;
endpackage

// File: rtl/dacif_decode.sv
module dacif_decode import dacif_pkg::*; #(
  parameter int unsigned NCH = DEF_NCH,
  parameter int unsigned AW  = DEF_AW
) (
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic           rd_en,
  input  logic [AW-1:0]  rd_addr,
  output logic           wr_mode,
  output logic           wr_range,
  output logic [NCH-1:0] wr_chan,
  output logic           rd_mode,
  output logic           rd_range
);
  assign wr_mode  = wr_en && (wr_addr == AW'(OFS_MODE));
  assign wr_range = wr_en && (wr_addr == AW'(OFS_RANGE));
  assign rd_mode  = rd_en && (rd_addr == AW'(OFS_MODE));
  assign rd_range = rd_en && (rd_addr == AW'(OFS_RANGE));

  for (genvar n = 0; n < NCH; n++) begin : g_dec
    localparam int unsigned CH_OFS = OFS_DATA0 + OFS_STEP * n;
    assign wr_chan[n] = wr_en && (wr_addr == AW'(CH_OFS));
  end

  always_comb begin
    AST_ONE_TARGET: assert ($countones({wr_mode, wr_range, wr_chan}) <= 1); // R2
  end
endmodule

// File: rtl/dacif_chan.sv
module dacif_chan #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  input  logic          buffered,
  input  logic          commit,
  input  logic          en_next,
  output logic [CW-1:0] code_o
);
  logic [CW-1:0] hold_q, active_q, active_d;

  always_comb begin
    active_d = active_q;
    if (commit && buffered)
      active_d = hold_q;
    else if (wr && !buffered)
      active_d = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      active_q <= '0;
      code_o   <= '0;
    end else begin
      if (wr) hold_q <= wdata;
      active_q <= active_d;
      code_o   <= en_next ? active_d : '0;
    end
  end

  AST_OFF_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !en_next |=> code_o == '0); // R3
  AST_BUF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (buffered && !commit) |=> $stable(active_q)); // R5
  AST_COMMIT_OLD: assert property (@(posedge clk) disable iff (rst)
    (buffered && commit) |=> active_q == $past(hold_q)); // R7
  AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (rst)
    (wr && !buffered && en_next) |=> code_o == $past(wdata)); // R4
endmodule

// File: rtl/dacif_range.sv
module dacif_range #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic [NCH-1:0] bip_w,
  input  logic [NCH-1:0] gain_w,
  input  logic           commit,
  output logic [NCH-1:0] bip_o,
  output logic [NCH-1:0] gain_o
);
  logic [NCH-1:0] bip_pend_q, gain_pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bip_pend_q  <= '0;
      gain_pend_q <= '0;
      bip_o       <= '0;
      gain_o      <= '0;
    end else begin
      if (wr) begin
        bip_pend_q  <= bip_w;
        gain_pend_q <= gain_w;
      end
      if (commit) begin
        bip_o  <= bip_pend_q;
        gain_o <= gain_pend_q;
      end
    end
  end

  AST_RANGE_STILL: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(bip_o) && $stable(gain_o))); // R8
  AST_RANGE_OLD: assert property (@(posedge clk) disable iff (rst)
    commit |=> (bip_o == $past(bip_pend_q) && gain_o == $past(gain_pend_q))); // R8
endmodule

// File: rtl/dbuf_dac_if.sv
module dbuf_dac_if import dacif_pkg::*; #(
  parameter int unsigned NCH = DEF_NCH,
  parameter int unsigned CW  = DEF_CW,
  parameter int unsigned DW  = DEF_DW,
  parameter int unsigned AW  = DEF_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [NCH*CW-1:0] dac_code_o,
  output logic [NCH-1:0]    dac_bipolar_o,
  output logic [NCH-1:0]    dac_gain_o
);
  logic           wr_mode, wr_range, rd_mode, rd_range;
  logic [NCH-1:0] wr_chan;
  logic [NCH-1:0] bip_w, gain_w;
  mode_t          mode_q;
  logic           en_next;
  logic           unused_hi;

  assign unused_hi = ^wr_data[DW-1:CW];

  dacif_decode #(.NCH(NCH), .AW(AW)) u_decode (
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en), .rd_addr(rd_addr),
    .wr_mode(wr_mode), .wr_range(wr_range), .wr_chan(wr_chan),
    .rd_mode(rd_mode), .rd_range(rd_range)
  );

  always_ff @(posedge clk) begin
    if (rst)
      mode_q <= '0;
    else if (wr_mode)
      mode_q <= '{en: wr_data[EN_BIT], buffered: wr_data[BUF_BIT]};
  end

  assign en_next = wr_mode ? wr_data[EN_BIT] : mode_q.en;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam int unsigned BIP_POS  = BIP_TOP - n;
    localparam int unsigned GAIN_POS = GAIN_TOP - n;
    assign bip_w[n]  = wr_data[BIP_POS];
    assign gain_w[n] = wr_data[GAIN_POS];

    dacif_chan #(.CW(CW)) u_chan (
      .clk(clk), .rst(rst), .wr(wr_chan[n]), .wdata(wr_data[CW-1:0]),
      .buffered(mode_q.buffered), .commit(rd_mode), .en_next(en_next),
      .code_o(dac_code_o[n*CW +: CW])
    );
  end

  dacif_range #(.NCH(NCH)) u_range (
    .clk(clk), .rst(rst), .wr(wr_range), .bip_w(bip_w), .gain_w(gain_w),
    .commit(rd_range), .bip_o(dac_bipolar_o), .gain_o(dac_gain_o)
  );

  AST_MODE_LATE: assert property (@(posedge clk) disable iff (rst)
    (wr_mode && !mode_q.buffered) |=> mode_q.buffered == $past(wr_data[BUF_BIT])); // R10
endmodule

// File: tb/dbuf_dac_if_bench.sv
`timescale 1ns/1ps
module dbuf_dac_if_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [47:0] dac_code_o;
  logic [3:0]  dac_bipolar_o, dac_gain_o;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 0;
  string cur_req = "R1";

  // reference model state
  int    m_hold[4];
  int    m_act[4];
  int    e_code[4];
  bit    m_en, m_buf;
  int    m_rpend, m_ract;
  bit    en_new;
  int    wd12;

  always #4 clk = ~clk;

  dbuf_dac_if u_dbuf_dac_if (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .dac_code_o(dac_code_o),
    .dac_bipolar_o(dac_bipolar_o), .dac_gain_o(dac_gain_o)
  );

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin m_hold[i] = 0; m_act[i] = 0; e_code[i] = 0; end
      m_en = 0; m_buf = 0; m_rpend = 0; m_ract = 0;
    end else begin
      wd12 = int'(wr_data) & 'hFFF;
      en_new = (wr_en && wr_addr == 8'h02) ? wr_data[1] : m_en;
      for (int i = 0; i < 4; i++) begin
        bit wr_i;
        wr_i = wr_en && (wr_addr == 8'(8'h14 + 2 * i));
        if (rd_en && rd_addr == 8'h02 && m_buf) m_act[i] = m_hold[i];
        else if (wr_i && !m_buf) m_act[i] = wd12;
        if (wr_i) m_hold[i] = wd12;
        e_code[i] = en_new ? m_act[i] : 0;
      end
      if (rd_en && rd_addr == 8'h12) m_ract = m_rpend;
      if (wr_en && wr_addr == 8'h12) m_rpend = int'(wr_data);
      if (wr_en && wr_addr == 8'h02) begin m_en = wr_data[1]; m_buf = wr_data[0]; end
    end
  end

  function automatic int code_of(int ch);
    return int'(dac_code_o[ch*12 +: 12]);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int i = 0; i < 4; i++) check(cur_req, $sformatf("model code ch%0d", i), code_of(i), e_code[i]);
      for (int i = 0; i < 4; i++) begin
        check(cur_req, $sformatf("model bipolar ch%0d", i), int'(dac_bipolar_o[i]), (m_ract >> (7 - i)) & 1);
        check(cur_req, $sformatf("model gain ch%0d", i), int'(dac_gain_o[i]), (m_ract >> (11 - i)) & 1);
      end
    end
  end

  task automatic op(bit w, logic [7:0] wa, logic [15:0] wd, bit r, logic [7:0] ra);
    wr_en = w; wr_addr = wa; wr_data = wd; rd_en = r; rd_addr = ra;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d); op(1, a, d, 0, 8'h00); endtask
  task automatic rd(logic [7:0] a); op(0, 8'h00, 16'h0, 1, a); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1_600_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_req = "R1";
    check("R1", "codes after reset", int'(dac_code_o[31:0]) | int'(dac_code_o[47:32]), 0);
    check("R1", "flags after reset", int'({dac_bipolar_o, dac_gain_o}), 0);

    cur_req = "R3";
    wr(8'h14, 16'h0123);
    check("R3", "ch0 held at zero while disabled", code_of(0), 0);
    wr(8'h02, 16'h0002);
    check("R3", "ch0 shown after enable", code_of(0), 'h123);

    cur_req = "R2";
    wr(8'h16, 16'hF456);
    check("R2", "ch1 upper bits masked", code_of(1), 'h456);

    cur_req = "R4";
    wr(8'h18, 16'h0789);
    check("R4", "ch2 direct write", code_of(2), 'h789);
    check("R4", "ch3 untouched", code_of(3), 0);

    cur_req = "R10";
    op(1, 8'h02, 16'h0003, 0, 8'h00);
    check("R10", "ch2 unchanged by mode write", code_of(2), 'h789);

    cur_req = "R5";
    wr(8'h14, 16'h0AAA);
    wr(8'h1A, 16'h0555);
    check("R5", "ch0 kept in buffered mode", code_of(0), 'h123);
    check("R5", "ch3 kept in buffered mode", code_of(3), 0);

    cur_req = "R6";
    rd(8'h02);
    check("R6", "ch0 after update", code_of(0), 'hAAA);
    check("R6", "ch1 after update", code_of(1), 'h456);
    check("R6", "ch2 after update", code_of(2), 'h789);
    check("R6", "ch3 after update", code_of(3), 'h555);

    cur_req = "R7";
    op(1, 8'h16, 16'h0111, 1, 8'h02);
    check("R7", "ch1 takes prior value", code_of(1), 'h456);
    rd(8'h02);
    check("R7", "ch1 new value on next update", code_of(1), 'h111);

    cur_req = "R10";
    op(1, 8'h14, 16'h0BBB, 0, 8'h00);
    op(1, 8'h02, 16'h0002, 0, 8'h00);
    check("R10", "write in last buffered cycle held", code_of(0), 'hAAA);
    wr(8'h14, 16'h0CCC);
    check("R10", "direct mode after switch", code_of(0), 'hCCC);

    cur_req = "R8";
    wr(8'h12, 16'h03A0);
    check("R8", "flags unchanged by write", int'({dac_bipolar_o, dac_gain_o}), 0);
    rd(8'h12);
    check("R8", "bipolar after commit", int'(dac_bipolar_o), 'b0101);
    check("R8", "gain after commit", int'(dac_gain_o), 'b1100);
    op(1, 8'h12, 16'h0FF0, 1, 8'h12);
    check("R8", "same-cycle commit keeps older word", int'({dac_bipolar_o, dac_gain_o}), 'b0101_1100);
    rd(8'h12);
    check("R8", "newer word on next commit", int'({dac_bipolar_o, dac_gain_o}), 'hFF);

    cur_req = "R9";
    wr(8'h02, 16'h0000);
    wr(8'h12, 16'h0000);
    rd(8'h12);
    check("R9", "codes back to reset", int'(dac_code_o[31:0]) | int'(dac_code_o[47:32]), 0);
    check("R9", "flags back to reset", int'({dac_bipolar_o, dac_gain_o}), 0);

    cur_req = "R6";
    for (int k = 0; k < 600; k++) begin
      int sel;
      logic [7:0] wa;
      sel = int'($urandom_range(0, 9));
      case (sel)
        0: wa = 8'h02;
        1: wa = 8'h12;
        2: wa = 8'h20;
        default: wa = 8'(8'h14 + 2 * (sel % 4));
      endcase
      op(($urandom_range(0, 3) != 0), wa,
         (wa == 8'h02) ? 16'($urandom_range(0, 3)) : 16'($urandom),
         ($urandom_range(0, 2) == 0), ($urandom_range(0, 1) != 0) ? 8'h02 : 8'h12);
    end

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule